// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a running nanosecond time for a precision time protocol clock. On every enabled reference clock the counter grows by a programmable step. The step is seven bits wide. Frequency is trimmed without a fractional accumulator: once per programmable correction interval, a second step value is used in place of the normal one. When period wrapping is on, the counter folds back at a programmable event period. A period of 2^31 gives a 31-bit time base.

Software reaches the block through a simple word-addressed write port and a combinational read port. The live count cannot be read directly. Software first writes a capture request into the control register. The count is then frozen into a latch, and reads of the time address return that latch. A write to the time address loads the counter directly. A restart request clears the counter and the correction phase. When enabled, a one-cycle pulse marks each period wrap, so that neighbouring compare logic can follow the wrap.

Top module: `ns_time_counter`

Word address map: 0 control, 1 time, 2 event period, 3 correction interval, 4 step. Any other address reads zero.

## Requirements
- R1: After reset, every register reads zero, the counter does not advance and `wrapEvt` is low.
- R2: While control bit 0 is set, the counter advances each clock by the normal step, which is held in bits 6:0 of the step register at address 4. While bit 0 is clear, the counter holds its value.
- R3: When the correction interval P at address 3 is nonzero, every (P+1)-th enabled clock adds the correction step held in bits 14:8 of the step register instead of the normal step. P = 0 means the normal step is always used.
- R4: When control bit 4 is set and the event period at address 2 is nonzero, a sum that reaches or passes the period becomes the sum minus the period. An exact hit therefore gives zero, and a period of 2^31 keeps the count within 31 bits.
- R5: Writing control bit 11 makes the next clock edge latch the count held before that edge. Reads of address 1 return the latch, and the latch stays unchanged until the next capture. Bit 11 reads back as 1 for exactly one cycle.
- R6: A write to address 1 loads the written value into the counter at that clock edge. The correction phase is left unchanged.
- R7: Writing control bit 9 clears the counter and the correction phase at the following edge, and the bit then clears itself. If a time load falls on that same edge, the restart wins.
- R8: When control bits 7 and 4 are both set, `wrapEvt` is high for one cycle, in the cycle right after each edge at which the counter wrapped.
- R9: Control bits 5 and 13 are stored and read back, and they have no effect on counting. Control bits not named in these requirements read as zero.
- R10: If a capture and a time load fall on the same edge, the latch receives the count from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Word address of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Word address of the read |
| rdData | output | 32 | Read data, combinational from `rdAddr` |
| wrapEvt | output | 1 | One-cycle pulse after a period wrap |

## Verification
Two pairs of functions can land on the same clock edge: capture with a time load, and restart with a time load. The bench provokes the first by writing the capture bit and then writing the time register in the very next cycle, so the pending capture and the load share one edge. The latch must then show the pre-load count. It provokes the second the same way with the restart bit, and the counter must come out at zero. A single control write that sets both restart and capture is also judged: the latch keeps the old count while the counter clears.

// File: rtl/ns_time_pkg.sv
package ns_time_pkg;

  // control register bit positions
  localparam int CtlEnBit      = 0;
  localparam int CtlWrapBit    = 4;
  localparam int CtlWrapAuxBit = 5;
  localparam int CtlPulseBit   = 7;
  localparam int CtlRestartBit = 9;
  localparam int CtlCaptureBit = 11;
  localparam int CtlSlaveBit   = 13;

  // word addresses
  localparam int AdrCtrl   = 0;
  localparam int AdrTime   = 1;
  localparam int AdrPeriod = 2;
  localparam int AdrCorr   = 3;
  localparam int AdrStep   = 4;

  typedef struct packed {
    logic restart;
    logic capture;
    logic load;
  } tcStrobe_t;

  typedef struct packed {
    logic enable;
    logic wrapEn;
    logic wrapOut;
  } tcCfg_t;

endpackage

// File: rtl/ns_time_ctrl.sv
module ns_time_ctrl
  import ns_time_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int STEP_W   = 7,
  parameter int CORR_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] latchVal,
  output tcStrobe_t         strb,
  output tcCfg_t            cfg,
  output logic [STEP_W-1:0] normStep,
  output logic [STEP_W-1:0] corrStep,
  output logic [DATA_W-1:0] evtPeriod,
  output logic [DATA_W-1:0] corrPeriod
);

  localparam int CtlCount = 7;
  localparam int CtlBits [CtlCount] = '{CtlEnBit, CtlWrapBit, CtlWrapAuxBit,
                                        CtlPulseBit, CtlRestartBit,
                                        CtlCaptureBit, CtlSlaveBit};

  function automatic logic [DATA_W-1:0] ctlMaskCalc();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < CtlCount; i++) m[CtlBits[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] stepMaskCalc();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < STEP_W; i++) begin
      m[i]            = 1'b1;
      m[CORR_LSB + i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CtlMask  = ctlMaskCalc();
  localparam logic [DATA_W-1:0] StepMask = stepMaskCalc();

  localparam logic [ADDR_W-1:0] ACtrl   = ADDR_W'(AdrCtrl);
  localparam logic [ADDR_W-1:0] ATime   = ADDR_W'(AdrTime);
  localparam logic [ADDR_W-1:0] APeriod = ADDR_W'(AdrPeriod);
  localparam logic [ADDR_W-1:0] ACorr   = ADDR_W'(AdrCorr);
  localparam logic [ADDR_W-1:0] AStep   = ADDR_W'(AdrStep);

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] stepReg;
  logic [DATA_W-1:0] periodReg;
  logic [DATA_W-1:0] corrReg;
  logic              ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == ACtrl);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      stepReg   <= '0;
      periodReg <= '0;
      corrReg   <= '0;
    end else begin
      if (ctrlWr) begin
        ctrlReg <= wrData & CtlMask;
      end else begin
        ctrlReg[CtlRestartBit] <= 1'b0;
        ctrlReg[CtlCaptureBit] <= 1'b0;
      end
      if (wrEn && wrAddr == AStep)   stepReg   <= wrData & StepMask;
      if (wrEn && wrAddr == APeriod) periodReg <= wrData;
      if (wrEn && wrAddr == ACorr)   corrReg   <= wrData;
    end
  end

  always_comb begin
    strb.restart = ctrlReg[CtlRestartBit];
    strb.capture = ctrlReg[CtlCaptureBit];
    strb.load    = wrEn && (wrAddr == ATime);
    cfg.enable   = ctrlReg[CtlEnBit];
    cfg.wrapEn   = ctrlReg[CtlWrapBit];
    cfg.wrapOut  = ctrlReg[CtlPulseBit];
  end

  assign normStep   = stepReg[STEP_W-1:0];
  assign corrStep   = stepReg[CORR_LSB +: STEP_W];
  assign evtPeriod  = periodReg;
  assign corrPeriod = corrReg;

  always_comb begin
    unique case (rdAddr)
      ACtrl:   rdData = ctrlReg;
      ATime:   rdData = latchVal;
      APeriod: rdData = periodReg;
      ACorr:   rdData = corrReg;
      AStep:   rdData = stepReg;
      default: rdData = '0;
    endcase
  end

  // R5
  capture_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && !ctrlWr |=> !strb.capture);

  // R7
  restart_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart && !ctrlWr |=> !strb.restart);

endmodule

// File: rtl/ns_time_datapath.sv
module ns_time_datapath
  import ns_time_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7,
  parameter int PER_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcStrobe_t         strb,
  input  tcCfg_t            cfg,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic [STEP_W-1:0] normStep,
  input  logic [STEP_W-1:0] corrStep,
  input  logic [CNT_W-1:0]  evtPeriod,
  input  logic [PER_W-1:0]  corrPeriod,
  output logic [CNT_W-1:0]  latchVal,
  output logic              wrapEvt
);

  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [PER_W-1:0]  phase;
  logic [CNT_W-1:0]  latchReg;
  logic              corrDue;
  logic [STEP_W-1:0] step;
  logic [SUM_W-1:0]  sum;
  logic              wrapHit;
  logic [CNT_W-1:0]  nextCnt;
  logic [PER_W-1:0]  nextPhase;
  logic              advance;

  always_comb begin
    corrDue   = (corrPeriod != '0) && (phase >= corrPeriod);
    step      = corrDue ? corrStep : normStep;
    sum       = {1'b0, cnt} + SUM_W'(step);
    wrapHit   = cfg.wrapEn && (evtPeriod != '0) && (sum >= {1'b0, evtPeriod});
    nextCnt   = wrapHit ? CNT_W'(sum - {1'b0, evtPeriod}) : sum[CNT_W-1:0];
    nextPhase = (corrDue || corrPeriod == '0) ? '0 : phase + 1'b1;
    advance   = cfg.enable && !strb.restart && !strb.load;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= '0;
    end else if (strb.restart) begin
      cnt   <= '0;
      phase <= '0;
    end else if (strb.load) begin
      cnt   <= loadVal;
    end else if (cfg.enable) begin
      cnt   <= nextCnt;
      phase <= nextPhase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchReg <= '0;
      wrapEvt  <= 1'b0;
    end else begin
      if (strb.capture) latchReg <= cnt;
      wrapEvt <= advance && wrapHit && cfg.wrapOut;
    end
  end

  assign latchVal = latchReg;

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (cnt == '0) && (phase == '0));

  // R5
  latch_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> latchReg == $past(cnt));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(latchReg));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable && !strb.restart && !strb.load |=> $stable(cnt));

  // R6
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && !strb.restart |=> cnt == $past(loadVal));

  // R8
  pulse_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.wrapOut |=> !wrapEvt);

endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
  import ns_time_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int STEP_W   = 7,
  parameter int CORR_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              wrapEvt
);

  tcStrobe_t         strb;
  tcCfg_t            cfg;
  logic [STEP_W-1:0] normStep;
  logic [STEP_W-1:0] corrStep;
  logic [DATA_W-1:0] evtPeriod;
  logic [DATA_W-1:0] corrPeriod;
  logic [DATA_W-1:0] latchVal;

  ns_time_ctrl #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .STEP_W  (STEP_W),
    .CORR_LSB(CORR_LSB)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .latchVal  (latchVal),
    .strb      (strb),
    .cfg       (cfg),
    .normStep  (normStep),
    .corrStep  (corrStep),
    .evtPeriod (evtPeriod),
    .corrPeriod(corrPeriod)
  );

  ns_time_datapath #(
    .CNT_W (DATA_W),
    .STEP_W(STEP_W),
    .PER_W (DATA_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfg       (cfg),
    .loadVal   (wrData),
    .normStep  (normStep),
    .corrStep  (corrStep),
    .evtPeriod (evtPeriod),
    .corrPeriod(corrPeriod),
    .latchVal  (latchVal),
    .wrapEvt   (wrapEvt)
  );

endmodule

// File: tb/test_ns_time_counter.sv
`timescale 1ns/1ps
module test_ns_time_counter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        wrapEvt;

  int    total = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  bit    live = 1'b0;
  string curReq = "R1";

  always #4 clk = ~clk;

  ns_time_counter i_ns_time_counter (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .wrapEvt(wrapEvt)
  );

  // behavioural reference state
  bit [31:0] mCtrl, mCnt, mPhase, mLatch, mPer, mCorr, mStep;
  bit        mWrap;

  function automatic bit [31:0] mRead(input bit [2:0] a);
    case (a)
      3'd0: return mCtrl;
      3'd1: return mLatch;
      3'd2: return mPer;
      3'd3: return mCorr;
      3'd4: return mStep;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit [31:0] nCtrl, nCnt, nPhase, nLatch;
    bit [32:0] s;
    bit        hit, due;
    if (!rstN) begin
      mCtrl = 0; mCnt = 0; mPhase = 0; mLatch = 0;
      mPer = 0; mCorr = 0; mStep = 0; mWrap = 0;
    end else begin
      nCnt = mCnt; nPhase = mPhase; nLatch = mLatch; hit = 0;
      if (mCtrl[9]) begin
        nCnt = 0; nPhase = 0;
      end else if (wrEn && wrAddr == 3'd1) begin
        nCnt = wrData;
      end else if (mCtrl[0]) begin
        due = (mCorr != 0) && (mPhase >= mCorr);
        s = {1'b0, mCnt} + (due ? {26'd0, mStep[14:8]} : {26'd0, mStep[6:0]});
        if (mCtrl[4] && mPer != 0 && s >= {1'b0, mPer}) begin
          s = s - {1'b0, mPer};
          hit = 1;
        end
        nCnt = s[31:0];
        nPhase = (mCorr == 0 || due) ? 0 : mPhase + 1;
      end
      if (mCtrl[11]) nLatch = mCnt;
      nCtrl = (wrEn && wrAddr == 3'd0) ? (wrData & 32'h2AB1) : (mCtrl & ~32'h0A00);
      if (wrEn && wrAddr == 3'd2) mPer = wrData;
      if (wrEn && wrAddr == 3'd3) mCorr = wrData;
      if (wrEn && wrAddr == 3'd4) mStep = wrData & 32'h7F7F;
      mWrap = hit && mCtrl[7];
      mCtrl = nCtrl; mCnt = nCnt; mPhase = nPhase; mLatch = nLatch;
    end
  end

  task automatic chk(input string req, input bit [31:0] act, input bit [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the reference, away from the active edge
  always @(negedge clk) begin
    #2;
    if (live) begin
      chk(curReq, rdData, mRead(rdAddr));
      chk({curReq, " R8 wrapEvt"}, {31'd0, wrapEvt}, {31'd0, mWrap});
    end
  end

  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input bit [2:0] a);
    rdAddr = a;
    #3;
    chk(curReq, rdData, mRead(a));
  endtask

  task automatic cap();
    wr(3'd0, (mCtrl & ~32'h0A00) | 32'h0800);
    idle(1);
    rd(3'd1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      fails++; total++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1: reset state
    curReq = "R1";
    for (int a = 0; a < 6; a++) begin
      rdAddr = 3'(a); #3;
      chk("R1 reset read", rdData, 32'd0);
      @(negedge clk);
    end
    chk("R1 wrapEvt", {31'd0, wrapEvt}, 32'd0);
    live = 1'b1;
    idle(4); cap();
    chk("R1 counter held", rdData, 32'd0);

    // R2: normal step and hold
    curReq = "R2";
    wr(3'd4, 32'd5); wr(3'd0, 32'd1);
    idle(10); cap();
    idle(3); cap();
    wr(3'd0, 32'd0); cap(); idle(6); cap();

    // R3: correction interval
    curReq = "R3";
    wr(3'd4, 32'h0000_0805); wr(3'd3, 32'd3); wr(3'd0, 32'd1);
    for (int k = 0; k < 6; k++) begin idle(k + 1); cap(); end
    wr(3'd3, 32'd0); idle(7); cap();
    wr(3'd3, 32'd1); idle(5); cap();

    // R6: direct load
    curReq = "R6";
    wr(3'd1, 32'h0000_1000); idle(3); cap();
    wr(3'd1, 32'hFFFF_FFFE); idle(2); cap();

    // R4 / R8: period wrap with pulse
    curReq = "R4";
    wr(3'd2, 32'd100); wr(3'd4, 32'd7); wr(3'd1, 32'd0);
    wr(3'd0, 32'h0000_0091);
    for (int k = 0; k < 8; k++) begin idle(3); cap(); end
    curReq = "R8";
    rdAddr = 3'd0; idle(40);
    wr(3'd2, 32'd70); idle(30);
    wr(3'd0, 32'h0000_0011); idle(30);
    curReq = "R4";
    wr(3'd2, 32'h8000_0000); wr(3'd4, 32'd3);
    wr(3'd1, 32'h7FFF_FFF0); idle(5); cap(); idle(4); cap();

    // R7: restart, and restart against load on the same edge
    curReq = "R7";
    wr(3'd0, 32'h0000_0001); wr(3'd2, 32'd0);
    idle(5);
    wr(3'd0, 32'h0000_0201); rd(3'd0); idle(1); rd(3'd0);
    cap();
    wr(3'd0, 32'h0000_0200); wr(3'd1, 32'h0000_5555); cap();
    chk("R7 restart beats load", rdData, 32'd0);

    // R10: capture and load on the same edge
    curReq = "R10";
    wr(3'd0, 32'h0000_0001); wr(3'd1, 32'h0000_0300); idle(2);
    wr(3'd0, 32'h0000_0801); wr(3'd1, 32'h0000_9999); rd(3'd1);
    wr(3'd0, 32'h0000_0A01); rd(3'd1); cap();

    // R5: capture bit readback and latch stability
    curReq = "R5";
    wr(3'd0, 32'h0000_0801); rd(3'd0);
    idle(1); rd(3'd0); rd(3'd1);
    idle(10); rd(3'd1);

    // R9: stored-only bits
    curReq = "R9";
    wr(3'd0, 32'hFFFF_D5CF); rd(3'd0);
    wr(3'd0, 32'h0000_2021); rd(3'd0);
    idle(5); cap();
    wr(3'd0, 32'h0000_0001); idle(5); cap();

    live = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule